// File: doc/BRIEF.md
# Double-Buffered USB IN Endpoint Controller

This block sits between endpoint firmware and the serial interface engine (SIE) of a USB device. It controls the buffers of one IN endpoint. It has two packet buffers, and firmware and the SIE use them in turn. Firmware writes bytes into the current fill buffer and then pulses a commit strobe. Only committed bytes can go out. Once the first buffer is committed, firmware can start filling the second buffer straight away.

On each IN token the block answers one cycle later. It pulses `sie_send` when a committed packet is waiting, and `sie_nack` when none is. For a send it presents the packet length, and then presents the bytes one at a time as the SIE pulls them. A buffer is freed only when the host handshake reports ACK. A timeout leaves the packet in place for a retry. After an ACK, the next token is served from the other buffer if that buffer is committed. Packets therefore leave in the order they were committed.

The status outputs are:
- an endpoint-empty flag, which reads 1 while at least one buffer is free;
- a sticky flag that records each IN token seen;
- a sticky overrun error;
- a data-toggle bit;
- an interrupt request, gated by two enable inputs.

Top module: `inep_pingpong`

## Requirements
- R1: After synchronous reset, `ep_empty`=1 and `sie_send`, `sie_nack`, `txreq_flag`, `ovr_err`, `data_toggle` and `irq` are all 0. Both buffer selectors point at buffer 0.
- R2: `ep_empty` is 0 exactly while both buffers hold committed packets, and 1 otherwise.
- R3: An IN token seen while no committed packet exists causes `sie_nack`=1 and `sie_send`=0 in the following cycle.
- R4: An IN token seen while a committed packet exists causes `sie_send`=1 in the following cycle. `sie_len` then equals the number of bytes committed. `sie_data` shows the bytes in the order written, and each `sie_rd` pulse advances it by one byte.
- R5: A `sie_timeout` leaves the sent buffer committed. The next IN token resends the same length and bytes.
- R6: Packets go out in commit order. After an ACK, the next token is served from the other buffer without any firmware action.
- R7: Bytes that are written but not yet committed are never sent. A token arriving while the only data is uncommitted gets NACK.
- R8: Every IN token sets `txreq_flag`. A `fw_txreq_clr` pulse clears it. If a token and a clear arrive in the same cycle, the flag ends up set.
- R9: `irq` = (`ep_empty` AND `irq_en_empty`) OR (`txreq_flag` AND `irq_en_txreq`). The status flags stay readable while both enables are 0.
- R10: A byte write while both buffers are committed is dropped and sets `ovr_err`. `ovr_err` then stays set until reset. The stored packets are unchanged.
- R11: Committing with no bytes written creates a zero-length packet. It is answered with `sie_send`=1 and `sie_len`=0.
- R12: `data_toggle` starts at 0 and inverts on every ACK received for a sent packet. It changes at no other time.
- R13: Each buffer holds at most DEPTH (64) bytes. Writes beyond that are dropped, and the committed length stays DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fw_wr_en | input | 1 | Firmware byte-write strobe |
| fw_wr_data | input | W | Byte to append to the fill buffer |
| fw_commit | input | 1 | Packet-enable strobe; commits the fill buffer |
| fw_txreq_clr | input | 1 | Clears the token-seen flag |
| irq_en_empty | input | 1 | Interrupt enable for `ep_empty` |
| irq_en_txreq | input | 1 | Interrupt enable for `txreq_flag` |
| sie_in_tok | input | 1 | IN token received (one-cycle pulse) |
| sie_rd | input | 1 | SIE pulls the current byte |
| sie_ack | input | 1 | Host returned ACK for the sent packet |
| sie_timeout | input | 1 | Host handshake timed out |
| sie_send | output | 1 | Send decision, one cycle after a token |
| sie_nack | output | 1 | NACK decision, one cycle after a token |
| sie_len | output | $clog2(DEPTH+1) | Length of the packet being sent |
| sie_data | output | W | Current byte of the packet |
| data_toggle | output | 1 | DATA0/DATA1 tracking bit |
| ep_empty | output | 1 | At least one buffer is free |
| txreq_flag | output | 1 | Sticky flag: IN token seen |
| ovr_err | output | 1 | Sticky flag: write while both buffers full |
| irq | output | 1 | Interrupt request |

## Verification
`sie_send` and `sie_nack` appear one cycle after the token. The bench therefore drives each stimulus for one cycle, from falling edge to falling edge, and samples the reply at the falling edge that follows the registering rising edge. `ep_empty`, `txreq_flag`, `ovr_err` and `data_toggle` are registered one clock after their cause, and are read at that same falling edge. `sie_len` and `sie_data` follow the read selector and byte index combinationally. Each byte is compared before its `sie_rd` pulse, and the next byte after the edge that consumes the pulse. `irq` is combinational from registered flags and from the enables, so it is checked in the same half cycle that the enables change.

// File: rtl/inep_pkg.sv
package inep_pkg;

    // reply of the endpoint to one IN token
    typedef struct packed {
        logic send;
        logic nack;
    } reply_t;

    localparam reply_t REPLY_NONE = '{send: 1'b0, nack: 1'b0};

    // pick the reply for a token given whether the read buffer is committed
    function automatic reply_t token_reply(input logic committed);
        reply_t r;
        r.send = committed;
        r.nack = !committed;
        return r;
    endfunction

    // selector advance between the two buffers
    function automatic logic flip_sel(input logic s);
        return !s;
    endfunction

endpackage

// File: rtl/inep_buf.sv
module inep_buf #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned W     = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          commit,
    input  logic          rel,
    input  logic [AW-1:0] raddr,
    output logic          valid,
    output logic [CW-1:0] len,
    output logic [W-1:0]  rdata
);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] fill;
    logic          room;

    assign room  = fill < CW'(DEPTH);
    assign rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (wr && room && !commit) begin
            mem[fill[AW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill  <= '0;
            len   <= '0;
            valid <= 1'b0;
        end else begin
            if (commit) begin
                valid <= 1'b1;
                len   <= fill;
                fill  <= '0;
            end else if (wr && room) begin
                fill <= fill + 1'b1;
            end
            if (rel) begin
                valid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/inep_wrctl.sv
module inep_wrctl (
    input  logic clk,
    input  logic rst,
    input  logic fw_wr_en,
    input  logic fw_commit,
    input  logic sel_busy,
    output logic wr_sel,
    output logic ovr
);
    import inep_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_sel <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            if (fw_commit && !sel_busy) begin
                wr_sel <= flip_sel(wr_sel);
            end
            if (fw_wr_en && sel_busy) begin
                ovr <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/inep_rdctl.sv
module inep_rdctl #(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sie_in_tok,
    input  logic          sie_rd,
    input  logic          sie_ack,
    input  logic          sie_timeout,
    input  logic          hit,
    input  logic [CW-1:0] cur_len,
    output logic          rd_sel,
    output logic [CW-1:0] rd_idx,
    output logic          send,
    output logic          nack,
    output logic          toggle,
    output logic          ack_ok
);
    import inep_pkg::*;

    logic   busy;
    reply_t reply;

    assign ack_ok = sie_ack && busy && !sie_in_tok;
    assign send   = reply.send;
    assign nack   = reply.nack;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_sel <= 1'b0;
            rd_idx <= '0;
            busy   <= 1'b0;
            toggle <= 1'b0;
            reply  <= REPLY_NONE;
        end else begin
            reply <= REPLY_NONE;
            if (sie_in_tok) begin
                reply  <= token_reply(hit);
                busy   <= hit;
                rd_idx <= '0;
            end else if (ack_ok) begin
                busy   <= 1'b0;
                rd_sel <= flip_sel(rd_sel);
                toggle <= !toggle;
            end else if (sie_timeout && busy) begin
                busy <= 1'b0;
            end else if (sie_rd && busy && rd_idx < cur_len) begin
                rd_idx <= rd_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/inep_pingpong.sv
module inep_pingpong #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned W     = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1),
    localparam int unsigned NBUF = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fw_wr_en,
    input  logic [W-1:0]  fw_wr_data,
    input  logic          fw_commit,
    input  logic          fw_txreq_clr,
    input  logic          irq_en_empty,
    input  logic          irq_en_txreq,
    input  logic          sie_in_tok,
    input  logic          sie_rd,
    input  logic          sie_ack,
    input  logic          sie_timeout,
    output logic          sie_send,
    output logic          sie_nack,
    output logic [CW-1:0] sie_len,
    output logic [W-1:0]  sie_data,
    output logic          data_toggle,
    output logic          ep_empty,
    output logic          txreq_flag,
    output logic          ovr_err,
    output logic          irq
);

    logic          valid_v [NBUF];
    logic [CW-1:0] len_v   [NBUF];
    logic [W-1:0]  rdata_v [NBUF];
    logic          wr_sel, rd_sel, ack_ok;
    logic [CW-1:0] rd_idx;

    generate
        for (genvar i = 0; i < NBUF; i++) begin : g_buf
            logic is_wr, is_rd;
            assign is_wr = (wr_sel == 1'(i));
            assign is_rd = (rd_sel == 1'(i));
            inep_buf #(.DEPTH(DEPTH), .W(W)) u_buf (
                .clk    (clk),
                .rst    (rst),
                .wr     (fw_wr_en && is_wr && !valid_v[i]),
                .wdata  (fw_wr_data),
                .commit (fw_commit && is_wr && !valid_v[i]),
                .rel    (ack_ok && is_rd),
                .raddr  (rd_idx[AW-1:0]),
                .valid  (valid_v[i]),
                .len    (len_v[i]),
                .rdata  (rdata_v[i])
            );
        end
    endgenerate

    inep_wrctl u_wr (
        .clk       (clk),
        .rst       (rst),
        .fw_wr_en  (fw_wr_en),
        .fw_commit (fw_commit),
        .sel_busy  (valid_v[wr_sel]),
        .wr_sel    (wr_sel),
        .ovr       (ovr_err)
    );

    inep_rdctl #(.DEPTH(DEPTH)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .sie_in_tok  (sie_in_tok),
        .sie_rd      (sie_rd),
        .sie_ack     (sie_ack),
        .sie_timeout (sie_timeout),
        .hit         (valid_v[rd_sel]),
        .cur_len     (len_v[rd_sel]),
        .rd_sel      (rd_sel),
        .rd_idx      (rd_idx),
        .send        (sie_send),
        .nack        (sie_nack),
        .toggle      (data_toggle),
        .ack_ok      (ack_ok)
    );

    assign sie_len  = len_v[rd_sel];
    assign sie_data = rdata_v[rd_sel];
    assign ep_empty = !(valid_v[0] && valid_v[1]);
    assign irq      = (ep_empty && irq_en_empty) || (txreq_flag && irq_en_txreq);

    // token-seen flag: a token in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst) begin
            txreq_flag <= 1'b0;
        end else if (sie_in_tok) begin
            txreq_flag <= 1'b1;
        end else if (fw_txreq_clr) begin
            txreq_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/inep_chk.sv
module inep_chk (
    input logic clk,
    input logic rst,
    input logic fw_wr_en,
    input logic sie_in_tok,
    input logic sie_ack,
    input logic sie_send,
    input logic sie_nack,
    input logic ep_empty,
    input logic txreq_flag,
    input logic ovr_err,
    input logic data_toggle,
    input logic irq,
    input logic irq_en_empty,
    input logic irq_en_txreq
);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (ep_empty && !txreq_flag && !ovr_err && !data_toggle && !sie_send && !sie_nack)); // R1

    AST_REPLY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sie_send && sie_nack)); // R3

    AST_TOKEN_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        sie_in_tok |=> (sie_send || sie_nack)); // R4

    AST_NO_SPURIOUS_REPLY: assert property (@(posedge clk) disable iff (rst)
        !sie_in_tok |=> (!sie_send && !sie_nack)); // R4

    AST_TXREQ_SET: assert property (@(posedge clk) disable iff (rst)
        sie_in_tok |=> txreq_flag); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (!irq_en_empty && !irq_en_txreq) |-> !irq); // R9

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovr_err |=> ovr_err); // R10

    AST_NO_OVR_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        (ep_empty && !ovr_err) |=> !ovr_err); // R10

    AST_TOGGLE_ONLY_ACK: assert property (@(posedge clk) disable iff (rst)
        !sie_ack |=> $stable(data_toggle)); // R12

endmodule

bind inep_pingpong inep_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .fw_wr_en     (fw_wr_en),
    .sie_in_tok   (sie_in_tok),
    .sie_ack      (sie_ack),
    .sie_send     (sie_send),
    .sie_nack     (sie_nack),
    .ep_empty     (ep_empty),
    .txreq_flag   (txreq_flag),
    .ovr_err      (ovr_err),
    .data_toggle  (data_toggle),
    .irq          (irq),
    .irq_en_empty (irq_en_empty),
    .irq_en_txreq (irq_en_txreq)
);

// File: tb/sim_inep_pingpong.sv
module sim_inep_pingpong;

    localparam int DEPTH = 64;
    localparam int W     = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fw_wr_en = 1'b0, fw_commit = 1'b0, fw_txreq_clr = 1'b0;
    logic [W-1:0]  fw_wr_data = '0;
    logic          irq_en_empty = 1'b0, irq_en_txreq = 1'b0;
    logic          sie_in_tok = 1'b0, sie_rd = 1'b0, sie_ack = 1'b0, sie_timeout = 1'b0;
    logic          sie_send, sie_nack, data_toggle, ep_empty, txreq_flag, ovr_err, irq;
    logic [CW-1:0] sie_len;
    logic [W-1:0]  sie_data;

    int n_chk = 0, n_bad = 0, acks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    inep_pingpong #(.DEPTH(DEPTH), .W(W)) u0 (.*);

    function automatic logic [W-1:0] pat(input int p, input int i);
        return W'((p * 37 + i * 11 + 5) & 255);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // every stimulus task is entered and left at a falling edge
    task automatic wr_byte(input logic [W-1:0] b);
        fw_wr_en = 1'b1; fw_wr_data = b;
        @(negedge clk);
        fw_wr_en = 1'b0;
    endtask

    task automatic commit();
        fw_commit = 1'b1;
        @(negedge clk);
        fw_commit = 1'b0;
    endtask

    task automatic token();
        sie_in_tok = 1'b1;
        @(negedge clk);
        sie_in_tok = 1'b0;
    endtask

    task automatic ack();
        sie_ack = 1'b1;
        @(negedge clk);
        sie_ack = 1'b0;
        acks++;
    endtask

    task automatic fill(input int p, input int n);
        for (int i = 0; i < n; i++) wr_byte(pat(p, i));
    endtask

    task automatic read_pkt(input string tag, input int p, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (sie_data != pat(p, i)) bad++;
            sie_rd = 1'b1;
            @(negedge clk);
            sie_rd = 1'b0;
        end
        check(tag, bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 ep_empty", ep_empty, 1);
        check("R1 send/nack", {sie_send, sie_nack}, 0);
        check("R1 flags", {txreq_flag, ovr_err, data_toggle, irq}, 0);

        // R3 token with nothing committed
        token();
        check("R3 nack", sie_nack, 1);
        check("R3 no send", sie_send, 0);
        check("R8 txreq set", txreq_flag, 1);
        fw_txreq_clr = 1'b1; @(negedge clk); fw_txreq_clr = 1'b0;
        check("R8 txreq cleared", txreq_flag, 0);

        // R7 uncommitted bytes are not sent
        fill(100, 3);
        token();
        check("R7 nack on uncommitted", sie_nack, 1);
        check("R7 no send", sie_send, 0);
        commit();
        token();
        check("R4 send", sie_send, 1);
        check("R4 len", sie_len, 3);
        read_pkt("R4 data", 100, 3);
        // R5 timeout keeps the packet
        sie_timeout = 1'b1; @(negedge clk); sie_timeout = 1'b0;
        token();
        check("R5 resend", sie_send, 1);
        check("R5 len", sie_len, 3);
        read_pkt("R5 data", 100, 3);
        ack();
        check("R12 toggle after ack", data_toggle, 1);
        check("R2 empty after ack", ep_empty, 1);

        // sweep every length 0..DEPTH through alternating buffers
        for (int n = 0; n <= DEPTH; n++) begin
            fill(n, n);
            commit();
            token();
            check(n == 0 ? "R11 zero-length send" : "R4 sweep send", sie_send, 1);
            check(n == 0 ? "R11 zero-length len" : "R4 sweep len", sie_len, n);
            read_pkt("R4 sweep data", n, n);
            ack();
            check("R12 toggle parity", data_toggle, acks % 2);
        end

        // ping-pong: two committed packets, order and overrun
        fill(200, 5);
        commit();
        check("R2 one buffer free", ep_empty, 1);
        fill(201, 9);
        commit();
        check("R2 both full", ep_empty, 0);
        check("R10 no overrun yet", ovr_err, 0);
        wr_byte(8'hEE);
        check("R10 overrun set", ovr_err, 1);
        token();
        check("R6 oldest first len", sie_len, 5);
        read_pkt("R6 oldest first data", 200, 5);
        ack();
        check("R2 free after ack", ep_empty, 1);
        token();
        check("R6 second served", sie_send, 1);
        check("R10 stored length unchanged", sie_len, 9);
        read_pkt("R10 stored data unchanged", 201, 9);
        ack();
        check("R10 overrun sticky", ovr_err, 1);

        // R13 capacity limit
        fill(300, DEPTH + 2);
        commit();
        token();
        check("R13 len capped", sie_len, DEPTH);
        read_pkt("R13 data", 300, DEPTH);
        ack();

        // R9 interrupt gating
        check("R9 irq off", irq, 0);
        irq_en_empty = 1'b1; #1;
        check("R9 irq from empty", irq, 1);
        irq_en_empty = 1'b0; irq_en_txreq = 1'b1; #1;
        check("R9 irq from txreq", irq, 1);
        @(negedge clk);
        fw_txreq_clr = 1'b1; @(negedge clk); fw_txreq_clr = 1'b0;
        check("R9 irq after clear", irq, 0);
        irq_en_txreq = 1'b0;
        token();
        check("R9 flag readable masked", txreq_flag, 1);
        check("R9 masked irq", irq, 0);

        // R8 token and clear together: set wins
        fw_txreq_clr = 1'b1; sie_in_tok = 1'b1;
        @(negedge clk);
        fw_txreq_clr = 1'b0; sie_in_tok = 1'b0;
        check("R8 set wins", txreq_flag, 1);

        // R1 reset again clears state
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        check("R1 reset clears flags", {txreq_flag, ovr_err, data_toggle}, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule